// File: doc/BRIEF.md
# Dual-Channel Partitioned Data Buffer

This block sits between two disk-interface channels and their consumers and holds data for both in a single physical store of `ENTRIES` words of `WORD_W` bits. By default that is 16 words of 32 bits, or 64 bytes. The store is split at run time into two logical FIFOs. The split can be half and half, or it can give the whole store to one channel. Each channel pushes and pops within its own share, and it sees its own level, empty and full outputs.

A channel that receives no storage still reaches its drive through a combinational pass-through path. Two control bytes set each channel's behaviour. One byte selects whether data is buffered ahead: read prefetch for the read direction, and write posting for the write direction. The other byte selects when the channel's contents must be drained before more data is accepted. A drain can be triggered at the end of every sector, or on an interrupt edge during a read transfer. A new split takes effect only once both logical FIFOs are empty.

Top module: `dchan_split_fifo`

## Requirements
- R1: After reset both channels report empty, level 0 and not full, and the even split is active.
- R2: Each channel returns its words in the order they were accepted, independently of the other channel. Its level rises by one for each accepted push and falls by one for each accepted pop.
- R3: With `split_mode_i`=0 each channel holds up to `ENTRIES/2` words. At that level `full_o` is high and `push_rdy_o` is low.
- R4: With `split_mode_i`=1, channel 0 holds up to `ENTRIES` words and channel 1 has no storage. In the same cycle, channel 1's `pop_vld_o` follows its `push_i`, `pop_data_o` equals `push_data_i`, and `push_rdy_o` follows `pop_i`. Its level stays 0.
- R5: With `split_mode_i`=2 the roles of R4 are swapped: channel 1 owns the whole store and channel 0 is pass-through.
- R6: `split_mode_i`=3, or any bit of `chan_idle_i` set, selects the even split.
- R7: A requested split is applied only in a cycle in which both levels are 0 and no word is written. Until then the previous capacities stay in force.
- R8: For channel c, the buffering enable is `xfer_cfg_i[4+2c]` (prefetch) when `rd_dir_i[c]`=1, and `xfer_cfg_i[5+2c]` (posting) when `rd_dir_i[c]`=0. When that enable is clear the channel holds at most one word, and it is full at level 1.
- R9: Every `SECTOR_WORDS` accepted pushes on a channel end a sector. If `flush_cfg_i[4+c]` is set, `push_rdy_o[c]` is low from the cycle after the ending push until the level has returned to 0.
- R10: A rising edge of `irq_i[c]` while `rd_dir_i[c]`=1 and `flush_cfg_i[6+c]`=1 stalls pushes on channel c until its level is 0. If either of those conditions is false, the edge has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| split_mode_i | input | 2 | Requested split: 0 even, 1 all to channel 0, 2 all to channel 1, 3 even |
| chan_idle_i | input | 2 | Per-channel unused flag; any set bit forces the even split |
| xfer_cfg_i | input | 8 | Buffering enables, bits 7:4 used (see R8) |
| flush_cfg_i | input | 8 | Drain enables, bits 7:4 used (see R9, R10) |
| rd_dir_i | input | 2 | Per-channel direction, 1 = read transfer |
| irq_i | input | 2 | Per-channel interrupt level |
| push_i | input | 2 | Per-channel push request |
| push_data_i | input | 2 x WORD_W | Per-channel push word |
| push_rdy_o | output | 2 | Per-channel push accepted this cycle if requested |
| pop_i | input | 2 | Per-channel pop request |
| pop_data_o | output | 2 x WORD_W | Per-channel head word |
| pop_vld_o | output | 2 | Per-channel head word valid |
| level_o | output | 2 x clog2(ENTRIES+1) | Per-channel stored word count |
| empty_o | output | 2 | Per-channel level is 0 |
| full_o | output | 2 | Per-channel level at its current limit |

## Verification
A corrupted pointer or base address appears at the first pop after it occurs, as a word out of order or taken from the other channel's share. The scoreboard catches it in that cycle. A wrong capacity or buffering limit shows within one push burst: the level stops at the wrong count, or `push_rdy_o` holds while it should drop. A drain flag that sets wrongly, or fails to clear, shows as `push_rdy_o` out of step with the level in the cycle after the sector end, the interrupt edge or the last pop. A split applied too early shows as an immediate change in how many pushes a half-full channel accepts.

// File: rtl/dsf_pkg.sv
package dsf_pkg;

   // Split selector, encoded as seen on split_mode_i
   typedef enum logic [1:0] {
      SPLIT_EVEN = 2'd0,
      SPLIT_ALL0 = 2'd1,
      SPLIT_ALL1 = 2'd2,
      SPLIT_ALT  = 2'd3
   } split_e;

endpackage

// File: rtl/dsf_split_cfg.sv
module dsf_split_cfg
   import dsf_pkg::*;
#(
   parameter int ENTRIES = 16,
   localparam int CW = $clog2(ENTRIES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    mode_i,
   input  logic [1:0]    idle_i,
   input  logic          quiet_i,
   output logic [CW-1:0] cap0_o,
   output logic [CW-1:0] cap1_o,
   output logic          load_o
);

   split_e req_s;
   split_e act_q;

   always_comb begin
      req_s = split_e'(mode_i);
      if ((|idle_i) || (req_s == SPLIT_ALT)) begin
         req_s = SPLIT_EVEN;
      end
   end

   // a new split is taken only while both logical queues are quiet
   assign load_o = quiet_i && (req_s != act_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= SPLIT_EVEN;
      end else if (load_o) begin
         act_q <= req_s;
      end
   end

   always_comb begin
      case (act_q)
         SPLIT_ALL0: begin
            cap0_o = CW'(ENTRIES);
            cap1_o = '0;
         end
         SPLIT_ALL1: begin
            cap0_o = '0;
            cap1_o = CW'(ENTRIES);
         end
         default: begin
            cap0_o = CW'(ENTRIES / 2);
            cap1_o = CW'(ENTRIES / 2);
         end
      endcase
   end

endmodule

// File: rtl/dsf_chan.sv
module dsf_chan #(
   parameter int ENTRIES      = 16,
   parameter int SECTOR_WORDS = 128,
   localparam int AW = $clog2(ENTRIES),
   localparam int CW = $clog2(ENTRIES + 1),
   localparam int SW = $clog2(SECTOR_WORDS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [CW-1:0] cap_i,
   input  logic          buf_en_i,
   input  logic          sec_flush_en_i,
   input  logic          irq_flush_en_i,
   input  logic          rd_dir_i,
   input  logic          irq_i,
   input  logic          push_i,
   input  logic          pop_i,
   output logic          push_rdy_o,
   output logic          pop_vld_o,
   output logic          wr_en_o,
   output logic [AW-1:0] wr_ptr_o,
   output logic [AW-1:0] rd_ptr_o,
   output logic [CW-1:0] level_o,
   output logic          full_o,
   output logic          empty_o
);

   logic [CW-1:0] cnt_q, cnt_n, limit_s;
   logic [AW-1:0] wp_q, rp_q;
   logic [SW-1:0] sec_q;
   logic          flush_q, irq_q;
   logic          bypass_s, at_lim_s, rd_en_s, xfer_s, sec_last_s, flush_go_s;

   function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p,
                                              input logic [CW-1:0] cap);
      return (CW'(p) == cap - CW'(1)) ? '0 : p + AW'(1);
   endfunction

   assign bypass_s = (cap_i == '0);
   assign limit_s  = buf_en_i ? cap_i : CW'(1);
   assign at_lim_s = (cnt_q >= limit_s);

   assign push_rdy_o = bypass_s ? pop_i  : (!at_lim_s && !flush_q);
   assign pop_vld_o  = bypass_s ? push_i : (cnt_q != '0);
   assign wr_en_o    = !bypass_s && push_i && !at_lim_s && !flush_q;
   assign rd_en_s    = !bypass_s && pop_i && (cnt_q != '0);
   assign xfer_s     = push_i && push_rdy_o;

   assign cnt_n = cnt_q + CW'(wr_en_o) - CW'(rd_en_s);

   // sector word counter: natural wrap when the sector size is a power of two
   if ((SECTOR_WORDS & (SECTOR_WORDS - 1)) == 0) begin : g_sec_wrap
      assign sec_last_s = &sec_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      sec_q <= '0;
         else if (xfer_s) sec_q <= sec_q + SW'(1);
      end
   end else begin : g_sec_cmp
      assign sec_last_s = (sec_q == SW'(SECTOR_WORDS - 1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      sec_q <= '0;
         else if (xfer_s) sec_q <= sec_last_s ? '0 : sec_q + SW'(1);
      end
   end

   assign flush_go_s = (xfer_s && sec_last_s && sec_flush_en_i) ||
                       (irq_i && !irq_q && rd_dir_i && irq_flush_en_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         wp_q    <= '0;
         rp_q    <= '0;
         flush_q <= 1'b0;
         irq_q   <= 1'b0;
      end else begin
         cnt_q   <= cnt_n;
         irq_q   <= irq_i;
         flush_q <= (flush_q || flush_go_s) && (cnt_n != '0);
         if (load_i) begin
            wp_q <= '0;
            rp_q <= '0;
         end else begin
            if (wr_en_o) wp_q <= step_ptr(wp_q, cap_i);
            if (rd_en_s) rp_q <= step_ptr(rp_q, cap_i);
         end
      end
   end

   assign wr_ptr_o = wp_q;
   assign rd_ptr_o = rp_q;
   assign level_o  = cnt_q;
   assign empty_o  = (cnt_q == '0);
   assign full_o   = !bypass_s && at_lim_s;

endmodule

// File: rtl/dchan_split_fifo.sv
module dchan_split_fifo #(
   parameter int WORD_W       = 32,
   parameter int ENTRIES      = 16,
   parameter int SECTOR_WORDS = 128,
   localparam int AW = $clog2(ENTRIES),
   localparam int CW = $clog2(ENTRIES + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [1:0]             split_mode_i,
   input  logic [1:0]             chan_idle_i,
   input  logic [7:0]             xfer_cfg_i,
   input  logic [7:0]             flush_cfg_i,
   input  logic [1:0]             rd_dir_i,
   input  logic [1:0]             irq_i,
   input  logic [1:0]             push_i,
   input  logic [1:0][WORD_W-1:0] push_data_i,
   output logic [1:0]             push_rdy_o,
   input  logic [1:0]             pop_i,
   output logic [1:0][WORD_W-1:0] pop_data_o,
   output logic [1:0]             pop_vld_o,
   output logic [1:0][CW-1:0]     level_o,
   output logic [1:0]             empty_o,
   output logic [1:0]             full_o
);

   if ((ENTRIES < 2) || (ENTRIES % 2 != 0)) begin : g_bad_entries
      $error("ENTRIES must be even and at least 2");
   end
   if (SECTOR_WORDS < 2) begin : g_bad_sector
      $error("SECTOR_WORDS must be at least 2");
   end
   if (WORD_W < 1) begin : g_bad_width
      $error("WORD_W must be positive");
   end

   logic [CW-1:0]     cap_s   [2];
   logic [AW-1:0]     wptr_s  [2];
   logic [AW-1:0]     rptr_s  [2];
   logic [AW-1:0]     base_s  [2];
   logic [AW-1:0]     waddr_s [2];
   logic [AW-1:0]     raddr_s [2];
   logic [1:0]        wr_en_s;
   logic              load_s, quiet_s;
   logic [WORD_W-1:0] mem_q [ENTRIES];
   logic              unused_cfg_bits;

   assign unused_cfg_bits = ^{xfer_cfg_i[3:0], flush_cfg_i[3:0]};

   assign quiet_s = (level_o[0] == '0) && (level_o[1] == '0) && !(|wr_en_s);

   dsf_split_cfg #(.ENTRIES(ENTRIES)) split_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode_i (split_mode_i),
      .idle_i (chan_idle_i),
      .quiet_i(quiet_s),
      .cap0_o (cap_s[0]),
      .cap1_o (cap_s[1]),
      .load_o (load_s)
   );

   // channel 1's share starts where channel 0's ends
   assign base_s[0] = '0;
   assign base_s[1] = cap_s[0][AW-1:0];

   for (genvar c = 0; c < 2; c++) begin : g_ch
      logic buf_en_s;
      assign buf_en_s = rd_dir_i[c] ? xfer_cfg_i[4 + 2*c] : xfer_cfg_i[5 + 2*c];

      dsf_chan #(.ENTRIES(ENTRIES), .SECTOR_WORDS(SECTOR_WORDS)) chan_i (
         .clk            (clk),
         .rst_n          (rst_n),
         .load_i         (load_s),
         .cap_i          (cap_s[c]),
         .buf_en_i       (buf_en_s),
         .sec_flush_en_i (flush_cfg_i[4 + c]),
         .irq_flush_en_i (flush_cfg_i[6 + c]),
         .rd_dir_i       (rd_dir_i[c]),
         .irq_i          (irq_i[c]),
         .push_i         (push_i[c]),
         .pop_i          (pop_i[c]),
         .push_rdy_o     (push_rdy_o[c]),
         .pop_vld_o      (pop_vld_o[c]),
         .wr_en_o        (wr_en_s[c]),
         .wr_ptr_o       (wptr_s[c]),
         .rd_ptr_o       (rptr_s[c]),
         .level_o        (level_o[c]),
         .full_o         (full_o[c]),
         .empty_o        (empty_o[c])
      );

      assign waddr_s[c] = base_s[c] + wptr_s[c];
      assign raddr_s[c] = base_s[c] + rptr_s[c];
      assign pop_data_o[c] = (cap_s[c] == '0) ? push_data_i[c] : mem_q[raddr_s[c]];
   end

   always_ff @(posedge clk) begin
      for (int c = 0; c < 2; c++) begin
         if (wr_en_s[c]) mem_q[waddr_s[c]] <= push_data_i[c];
      end
   end

endmodule

// File: rtl/dchan_split_fifo_chk.sv
module dchan_split_fifo_chk #(
   parameter int ENTRIES = 16,
   localparam int CW = $clog2(ENTRIES + 1)
) (
   input logic               clk,
   input logic               rst_n,
   input logic [1:0]         push_i,
   input logic [1:0]         push_rdy_o,
   input logic [1:0]         pop_i,
   input logic [1:0]         pop_vld_o,
   input logic [1:0]         empty_o,
   input logic [1:0][CW-1:0] level_o,
   input logic [CW-1:0]      cap0_i,
   input logic [CW-1:0]      cap1_i
);

   logic [CW-1:0] cap_a [2];
   assign cap_a[0] = cap0_i;
   assign cap_a[1] = cap1_i;

   for (genvar c = 0; c < 2; c++) begin : g_ch
      p_push_grow_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (push_i[c] && push_rdy_o[c] && !pop_i[c])
         |=> (level_o[c] == $past(level_o[c]) + CW'(1)));

      p_pop_shrink_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (pop_i[c] && pop_vld_o[c] && !push_i[c])
         |=> (level_o[c] == $past(level_o[c]) - CW'(1)));

      p_empty_no_vld_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (empty_o[c] && !push_i[c]) |-> !pop_vld_o[c]);

      p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
         level_o[c] <= cap_a[c]);

      p_bypass_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (cap_a[c] == '0) |-> empty_o[c]);
   end

   p_split_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cap0_i != $past(cap0_i)) |-> ($past(empty_o) == 2'b11));

endmodule

bind dchan_split_fifo dchan_split_fifo_chk #(.ENTRIES(ENTRIES)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .push_i    (push_i),
   .push_rdy_o(push_rdy_o),
   .pop_i     (pop_i),
   .pop_vld_o (pop_vld_o),
   .empty_o   (empty_o),
   .level_o   (level_o),
   .cap0_i    (cap_s[0]),
   .cap1_i    (cap_s[1])
);

// File: tb/dchan_split_fifo_tb_top.sv
module dchan_split_fifo_tb_top;

   localparam int W   = 32;
   localparam int N   = 16;
   localparam int SEC = 128;
   localparam int CW  = $clog2(N + 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [1:0]        split_mode_i = '0, chan_idle_i = '0;
   logic [7:0]        xfer_cfg_i = 8'hF0, flush_cfg_i = 8'h00;
   logic [1:0]        rd_dir_i = '0, irq_i = '0, push_i = '0, pop_i = '0;
   logic [1:0][W-1:0] push_data_i = '0;
   logic [1:0]        push_rdy_o, pop_vld_o, empty_o, full_o;
   logic [1:0][W-1:0] pop_data_o;
   logic [1:0][CW-1:0] level_o;

   int total = 0;
   int bad = 0;
   int xcnt [2];
   int seq = 0;
   logic [W-1:0] sq0 [$];
   logic [W-1:0] sq1 [$];

   always #2 clk = ~clk;

   dchan_split_fifo #(.WORD_W(W), .ENTRIES(N), .SECTOR_WORDS(SEC)) dut_i (.*);

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // monitor / scoreboard: record accepted pushes, compare accepted pops
   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         for (int c = 0; c < 2; c++) begin
            if (push_i[c] && push_rdy_o[c]) begin
               if (c == 0) sq0.push_back(push_data_i[c]);
               else        sq1.push_back(push_data_i[c]);
               xcnt[c]++;
            end
            if (pop_i[c] && pop_vld_o[c]) begin
               logic [W-1:0] e;
               if ((c == 0 && sq0.size() == 0) || (c == 1 && sq1.size() == 0)) begin
                  chk(1'b0, "R2 pop with nothing expected", pop_data_o[c], 0);
               end else begin
                  e = (c == 0) ? sq0.pop_front() : sq1.pop_front();
                  chk(pop_data_o[c] == e, "R2 pop order", pop_data_o[c], e);
               end
            end
         end
      end
   end

   task automatic push_cycles(input int c, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         push_i[c] = 1'b1;
         seq++;
         push_data_i[c] = W'(32'hA000_0000 + (c << 20) + seq);
      end
      @(negedge clk);
      push_i[c] = 1'b0;
   endtask

   task automatic drain(input int c);
      @(negedge clk);
      pop_i[c] = 1'b1;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (level_o[c] == '0) break;
      end
      pop_i[c] = 1'b0;
   endtask

   task automatic set_split(input logic [1:0] m, input logic [1:0] idle);
      @(negedge clk);
      split_mode_i = m;
      chan_idle_i  = idle;
      repeat (3) @(negedge clk);
   endtask

   task automatic bypass_check(input int c, input string tag);
      logic [W-1:0] d;
      @(negedge clk);
      d = W'(32'h5A5A_0000 + c);
      push_data_i[c] = d;
      push_i[c] = 1'b1;
      pop_i[c]  = 1'b0;
      #1;
      chk(pop_vld_o[c] == 1'b1, {tag, " vld follows push"}, pop_vld_o[c], 1);
      chk(pop_data_o[c] == d, {tag, " data passes"}, pop_data_o[c], d);
      chk(push_rdy_o[c] == 1'b0, {tag, " rdy follows pop low"}, push_rdy_o[c], 0);
      @(negedge clk);
      pop_i[c] = 1'b1;
      #1;
      chk(push_rdy_o[c] == 1'b1, {tag, " rdy follows pop high"}, push_rdy_o[c], 1);
      @(negedge clk);
      push_i[c] = 1'b0;
      pop_i[c]  = 1'b0;
      chk(level_o[c] == '0, {tag, " level stays 0"}, level_o[c], 0);
   endtask

   initial begin
      repeat (300000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int target;
      xcnt[0] = 0;
      xcnt[1] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk(empty_o == 2'b11, "R1 empty", empty_o, 3);
      chk(level_o[0] == '0 && level_o[1] == '0, "R1 levels", level_o, 0);
      chk(full_o == 2'b00, "R1 full", full_o, 0);

      // R3 even split (default after reset, R1) and R2 independence
      push_cycles(0, 10);
      chk(level_o[0] == CW'(N/2), "R3 level at half", level_o[0], N/2);
      chk(full_o[0] == 1'b1, "R3 full", full_o[0], 1);
      chk(push_rdy_o[0] == 1'b0, "R3 rdy low", push_rdy_o[0], 0);
      push_cycles(1, 3);
      chk(level_o[1] == CW'(3), "R2 other channel level", level_o[1], 3);
      chk(level_o[0] == CW'(N/2), "R2 first channel untouched", level_o[0], N/2);
      drain(0);
      drain(1);
      chk(empty_o == 2'b11, "R2 drained", empty_o, 3);

      // R4 whole store to channel 0
      set_split(2'd1, 2'b00);
      push_cycles(0, 18);
      chk(level_o[0] == CW'(N), "R4 level all", level_o[0], N);
      chk(full_o[0] == 1'b1, "R4 full", full_o[0], 1);
      bypass_check(1, "R4");

      // R7 request while busy is held
      @(negedge clk);
      pop_i[0] = 1'b1;
      repeat (4) @(negedge clk);
      pop_i[0] = 1'b0;
      set_split(2'd0, 2'b00);
      chk(level_o[0] == CW'(N - 4), "R7 level kept", level_o[0], N - 4);
      chk(push_rdy_o[0] == 1'b1, "R7 old capacity held", push_rdy_o[0], 1);
      drain(0);
      repeat (2) @(negedge clk);
      push_cycles(0, 10);
      chk(level_o[0] == CW'(N/2), "R7 new split after empty", level_o[0], N/2);
      drain(0);

      // R5 whole store to channel 1
      set_split(2'd2, 2'b00);
      push_cycles(1, 18);
      chk(level_o[1] == CW'(N), "R5 level all", level_o[1], N);
      chk(full_o[1] == 1'b1, "R5 full", full_o[1], 1);
      bypass_check(0, "R5");
      drain(1);

      // R6 fallbacks to even
      set_split(2'd3, 2'b00);
      push_cycles(1, 10);
      chk(level_o[1] == CW'(N/2), "R6 mode 3 even", level_o[1], N/2);
      drain(1);
      set_split(2'd2, 2'b01);
      push_cycles(1, 10);
      chk(level_o[1] == CW'(N/2), "R6 idle forces even", level_o[1], N/2);
      drain(1);
      set_split(2'd0, 2'b00);

      // R8 buffering enables
      @(negedge clk);
      xfer_cfg_i = 8'hD0;
      push_cycles(0, 3);
      chk(level_o[0] == CW'(1), "R8 posting off one word", level_o[0], 1);
      chk(full_o[0] == 1'b1, "R8 posting off full", full_o[0], 1);
      drain(0);
      rd_dir_i[0] = 1'b1;
      push_cycles(0, 3);
      chk(level_o[0] == CW'(3), "R8 prefetch on buffers", level_o[0], 3);
      drain(0);
      xfer_cfg_i = 8'hE0;
      push_cycles(0, 3);
      chk(level_o[0] == CW'(1), "R8 prefetch off one word", level_o[0], 1);
      drain(0);
      xfer_cfg_i = 8'hF0;
      rd_dir_i[0] = 1'b0;

      // R9 sector-end drain on channel 0
      target = xcnt[0] + ((125 - (xcnt[0] % SEC) + SEC) % SEC);
      forever begin
         @(negedge clk);
         if (xcnt[0] >= target + 3) break;
         push_i[0] = 1'b1;
         seq++;
         push_data_i[0] = W'(32'hC000_0000 + seq);
         pop_i[0] = (xcnt[0] < target);
         if (xcnt[0] >= target) flush_cfg_i = 8'h10;
      end
      push_i[0] = 1'b0;
      pop_i[0]  = 1'b0;
      chk(level_o[0] != '0, "R9 words left at sector end", level_o[0], 3);
      chk(push_rdy_o[0] == 1'b0, "R9 stall after sector end", push_rdy_o[0], 0);
      @(negedge clk);
      pop_i[0] = 1'b1;
      @(negedge clk);
      pop_i[0] = 1'b0;
      chk(push_rdy_o[0] == 1'b0, "R9 stall while draining", push_rdy_o[0], 0);
      drain(0);
      @(negedge clk);
      chk(push_rdy_o[0] == 1'b1, "R9 stall released", push_rdy_o[0], 1);
      flush_cfg_i = 8'h00;

      // R10 interrupt drain on channel 1
      rd_dir_i[1] = 1'b1;
      flush_cfg_i = 8'h80;
      push_cycles(1, 4);
      @(negedge clk);
      irq_i[1] = 1'b1;
      @(negedge clk);
      irq_i[1] = 1'b0;
      chk(level_o[1] == CW'(4), "R10 level held", level_o[1], 4);
      chk(push_rdy_o[1] == 1'b0, "R10 stall on irq", push_rdy_o[1], 0);
      drain(1);
      @(negedge clk);
      chk(push_rdy_o[1] == 1'b1, "R10 stall released", push_rdy_o[1], 1);
      rd_dir_i[1] = 1'b0;
      push_cycles(1, 2);
      @(negedge clk);
      irq_i[1] = 1'b1;
      @(negedge clk);
      irq_i[1] = 1'b0;
      chk(push_rdy_o[1] == 1'b1, "R10 ignored on write", push_rdy_o[1], 1);
      drain(1);
      rd_dir_i[1] = 1'b1;
      flush_cfg_i = 8'h00;
      push_cycles(1, 2);
      @(negedge clk);
      irq_i[1] = 1'b1;
      @(negedge clk);
      irq_i[1] = 1'b0;
      chk(push_rdy_o[1] == 1'b1, "R10 ignored when disabled", push_rdy_o[1], 1);
      chk(level_o[1] == CW'(2), "R10 level when disabled", level_o[1], 2);
      drain(1);

      @(negedge clk);
      chk(empty_o == 2'b11, "R2 end empty", empty_o, 3);
      chk(sq0.size() == 0 && sq1.size() == 0, "R2 scoreboard empty",
          sq0.size() + sq1.size(), 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule